// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar held in BCD and compares it with one programmable alarm word. The calendar supplies seconds, minutes, hours, day of month and weekday, along with a strobe that pulses once per calendar update (nominally 1 Hz). The alarm word holds a target value for each field. Each field also carries its own don't-care bit, and the day field can be set to compare either the day of month or the weekday. When every field that is not masked equals the calendar on an update strobe, and the alarm is enabled, a sticky alarm flag is set. The flag stays up until software clears it. The interrupt output is the flag gated by an interrupt enable.

The alarm word can be rewritten only while the alarm is disabled. Clearing the alarm enable starts a short handshake: a write-allowed status rises only after a fixed number of reference-clock ticks. Writes to the alarm word made before then are dropped. This matches the way a slow timekeeping domain hands the register over to the bus side.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the flag, the interrupt, both enables and the alarm word are all zero, and write-allowed is high.
- R2: A write to the alarm word takes effect only when the alarm is disabled and write-allowed is high. In every other case the word read back on alm_word_o is unchanged.
- R3: Setting the alarm enable drops write-allowed on the following cycle. After the enable is cleared, write-allowed rises at the clock edge that samples the WR_OK_DLY-th reference tick (2 by default). It stays low after fewer ticks.
- R4: The field positions in the alarm word are: seconds in bits 6:0, minutes in bits 14:8, hours in bits 21:16, day of month in bits 29:24. When all of them equal the calendar on an update strobe while the alarm is enabled, flag_o is high on the cycle after the strobe. A single mismatching field keeps the flag low.
- R5: The mask bits are 7 (seconds), 15 (minutes), 23 (hours) and 31 (day). Each one makes its field count as matching whatever the calendar holds.
- R6: With bit 30 set, bits 27:24 are compared against the weekday input (1 to 7) and the day of month is not compared.
- R7: Bit 22 (afternoon marker) has no effect on the comparison; hours are always compared in 24-hour form.
- R8: The flag does not set without an update strobe, and it does not set on a matching strobe while the alarm is disabled.
- R9: Once set, the flag stays set through later strobes and calendar changes until flag_clr_i is asserted. If a clear and a new match arrive in the same cycle, the flag stays set.
- R10: irq_o equals the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle pulse per reference clock period |
| ctrl_wr_i | input | 1 | Load both enable bits |
| ctrl_alarm_en_i | input | 1 | Alarm enable value to load |
| ctrl_irq_en_i | input | 1 | Interrupt enable value to load |
| alm_wr_i | input | 1 | Alarm word write strobe |
| alm_wdata_i | input | 32 | Alarm word write data |
| flag_clr_i | input | 1 | Clear the alarm flag |
| upd_i | input | 1 | Calendar update strobe |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 6 | Calendar hours, BCD 24-hour |
| cal_date_i | input | 6 | Calendar day of month, BCD |
| cal_wday_i | input | 3 | Calendar weekday, 1 to 7 |
| alm_word_o | output | 32 | Current alarm word |
| wr_ok_o | output | 1 | Alarm word writes are allowed |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its default WR_OK_DLY of 2. At that value the handshake can be checked tick by tick: write-allowed stays low after one tick and rises on the second. It also lets every vector reload the alarm word after only two reference ticks. The calendar is held at one fixed time, and the vector table varies the alarm word so that each field in turn mismatches, is masked, or is switched to weekday mode.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_TF = 3;
  // time fields: seconds, minutes, hours
  localparam int unsigned TF_LSB [NUM_TF] = '{0, 8, 16};
  localparam int unsigned TF_W   [NUM_TF] = '{7, 7, 6};
  localparam int unsigned TF_MSK [NUM_TF] = '{7, 15, 23};
  localparam int unsigned PM_BIT   = 22;
  localparam int unsigned DAY_LSB  = 24;
  localparam int unsigned DATE_W   = 6;
  localparam int unsigned WDAY_W   = 4;
  localparam int unsigned WSEL_BIT = 30;
  localparam int unsigned DMSK_BIT = 31;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] date;
    logic [2:0] wday;
  } cal_t;
endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int unsigned WR_OK_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_alarm_en_i,
  input  logic              ctrl_irq_en_i,
  input  logic              alm_wr_i,
  input  logic [WORD_W-1:0] alm_wdata_i,
  output logic              alarm_en_o,
  output logic              irq_en_o,
  output logic              wr_ok_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CW = (WR_OK_DLY > 1) ? $clog2(WR_OK_DLY) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(WR_OK_DLY - 1);

  logic              en_q, ie_q, wr_ok_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] word_q;
  logic              word_we;

  assign word_we = alm_wr_i & wr_ok_q & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      wr_ok_q <= 1'b1;
      cnt_q   <= '0;
      word_q  <= '0;
    end else begin
      if (ctrl_wr_i) begin
        en_q <= ctrl_alarm_en_i;
        ie_q <= ctrl_irq_en_i;
      end
      if (ctrl_wr_i && ctrl_alarm_en_i) begin
        wr_ok_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!en_q && !wr_ok_q && ref_tick_i) begin
        // count reference ticks since disable
        if (cnt_q == CNT_LAST) begin
          wr_ok_q <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (word_we) word_q <= alm_wdata_i;
    end
  end

  assign alarm_en_o = en_q;
  assign irq_en_o   = ie_q;
  assign wr_ok_o    = wr_ok_q;
  assign word_o     = word_q;

  AST_WROK_LOW_WHILE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> !wr_ok_q); // R3
  AST_WORD_FROZEN_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(word_q)); // R2
  AST_WROK_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_ok_q) |-> ($past(ref_tick_i) && !$past(en_q))); // R3
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  cal_t              cal_i,
  output logic              match_o
);
  logic [23:0]       tv;
  logic [NUM_TF-1:0] tf_hit;
  logic              day_hit, date_eq, wday_eq;
  logic              unused_cmp;

  // time fields laid out on the same bit positions as the alarm word
  assign tv = {2'b00, cal_i.hour, 1'b0, cal_i.min, 1'b0, cal_i.sec};

  for (genvar g = 0; g < NUM_TF; g++) begin : g_tf
    assign tf_hit[g] = word_i[TF_MSK[g]] |
                       (word_i[TF_LSB[g] +: TF_W[g]] == tv[TF_LSB[g] +: TF_W[g]]);
  end

  assign date_eq = (word_i[DAY_LSB +: DATE_W] == cal_i.date);
  assign wday_eq = (word_i[DAY_LSB +: WDAY_W] == {1'b0, cal_i.wday});
  assign day_hit = word_i[DMSK_BIT] | (word_i[WSEL_BIT] ? wday_eq : date_eq);
  assign match_o = (&tf_hit) & day_hit;

  // 24-hour operation: the afternoon marker takes no part
  assign unused_cmp = ^{word_i[PM_BIT], tv[7], tv[15], tv[23:22]};
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic match_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, hit;

  assign hit = upd_i & en_i & match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1; // a fresh match wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R9
  AST_NO_SET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(upd_i && en_i)) |=> !flag_q); // R8
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int unsigned WR_OK_DLY = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        ctrl_wr_i,
  input  logic        ctrl_alarm_en_i,
  input  logic        ctrl_irq_en_i,
  input  logic        alm_wr_i,
  input  logic [31:0] alm_wdata_i,
  input  logic        flag_clr_i,
  input  logic        upd_i,
  input  logic [6:0]  cal_sec_i,
  input  logic [6:0]  cal_min_i,
  input  logic [5:0]  cal_hour_i,
  input  logic [5:0]  cal_date_i,
  input  logic [2:0]  cal_wday_i,
  output logic [31:0] alm_word_o,
  output logic        wr_ok_o,
  output logic        flag_o,
  output logic        irq_o
);
  logic              alarm_en, irq_en, match, flag;
  logic [WORD_W-1:0] word;
  cal_t              cal;

  assign cal = '{sec: cal_sec_i, min: cal_min_i, hour: cal_hour_i,
                 date: cal_date_i, wday: cal_wday_i};

  cal_alarm_ctrl #(.WR_OK_DLY(WR_OK_DLY)) u_ctrl (
    .clk_i, .rst_ni, .ref_tick_i, .ctrl_wr_i, .ctrl_alarm_en_i, .ctrl_irq_en_i,
    .alm_wr_i, .alm_wdata_i,
    .alarm_en_o (alarm_en),
    .irq_en_o   (irq_en),
    .wr_ok_o    (wr_ok_o),
    .word_o     (word)
  );

  cal_alarm_cmp u_cmp (
    .word_i  (word),
    .cal_i   (cal),
    .match_o (match)
  );

  cal_alarm_flag u_flag (
    .clk_i, .rst_ni,
    .upd_i   (upd_i),
    .match_i (match),
    .en_i    (alarm_en),
    .clr_i   (flag_clr_i),
    .flag_o  (flag)
  );

  assign alm_word_o = word;
  assign flag_o     = flag;
  assign irq_o      = flag & irq_en;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R10
endmodule

// File: tb/tb_cal_alarm_top.sv
module tb_cal_alarm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 0, ctrl_wr = 0, ctrl_en = 0, ctrl_ie = 0;
  logic        alm_wr = 0, flag_clr = 0, upd = 0;
  logic [31:0] alm_wdata = '0;
  logic [6:0]  sec = 7'h45, mnt = 7'h30;
  logic [5:0]  hour = 6'h17, date = 6'h21;
  logic [2:0]  wday = 3'd3;
  logic [31:0] alm_word;
  logic        wr_ok, flag, irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cal_alarm_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick),
    .ctrl_wr_i(ctrl_wr), .ctrl_alarm_en_i(ctrl_en), .ctrl_irq_en_i(ctrl_ie),
    .alm_wr_i(alm_wr), .alm_wdata_i(alm_wdata), .flag_clr_i(flag_clr),
    .upd_i(upd), .cal_sec_i(sec), .cal_min_i(mnt), .cal_hour_i(hour),
    .cal_date_i(date), .cal_wday_i(wday),
    .alm_word_o(alm_word), .wr_ok_o(wr_ok), .flag_o(flag), .irq_o(irq)
  );

  // {expected flag, alarm word}; calendar fixed at 17:30:45, day 21, weekday 3
  localparam logic [32:0] VEC [13] = '{
    {1'b1, 32'h21173045},  // R4 exact
    {1'b0, 32'h21173044},  // R4 seconds differ
    {1'b1, 32'h211730C4},  // R5 seconds masked
    {1'b0, 32'h21173145},  // R4 minutes differ
    {1'b1, 32'h2117B145},  // R5 minutes masked
    {1'b0, 32'h21163045},  // R4 hours differ
    {1'b1, 32'h21963045},  // R5 hours masked
    {1'b0, 32'h22173045},  // R4 date differs
    {1'b1, 32'hA2173045},  // R5 day masked
    {1'b1, 32'h43173045},  // R6 weekday 3 selected
    {1'b0, 32'h44173045},  // R6 weekday 4 selected
    {1'b1, 32'h21573045},  // R7 afternoon marker set
    {1'b1, 32'h85818181}   // R5 every field masked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic en, input logic ie);
    ctrl_wr = 1; ctrl_en = en; ctrl_ie = ie;
    @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_word(input logic [31:0] w);
    alm_wr = 1; alm_wdata = w;
    @(negedge clk); alm_wr = 0;
  endtask
  task automatic tick();
    ref_tick = 1; @(negedge clk); ref_tick = 0;
  endtask
  task automatic pulse_upd();
    upd = 1; @(negedge clk); upd = 0;
  endtask
  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask
  task automatic reload(input logic [31:0] w);
    set_ctrl(0, 1); pulse_clr(); tick(); tick(); wr_word(w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag", {31'b0, flag}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wr_ok", {31'b0, wr_ok}, 1);
    chk("R1 word", alm_word, 0);

    foreach (VEC[i]) begin
      reload(VEC[i][31:0]);
      set_ctrl(1, 1);
      pulse_upd();
      chk("R4/R5/R6/R7 vector flag", {31'b0, flag}, {31'b0, VEC[i][32]});
      chk("R10 vector irq", {31'b0, irq}, {31'b0, VEC[i][32]});
    end

    // R2 / R3 handshake
    reload(32'h11111111);
    chk("R2 accepted", alm_word, 32'h11111111);
    set_ctrl(1, 1);
    chk("R3 low after enable", {31'b0, wr_ok}, 0);
    wr_word(32'h22222222);
    chk("R2 ignored while enabled", alm_word, 32'h11111111);
    set_ctrl(0, 1);
    wr_word(32'h22222222);
    chk("R2 ignored before wr_ok", alm_word, 32'h11111111);
    tick();
    chk("R3 low after one tick", {31'b0, wr_ok}, 0);
    tick();
    chk("R3 high after two ticks", {31'b0, wr_ok}, 1);
    wr_word(32'h21173045);
    chk("R2 accepted after handshake", alm_word, 32'h21173045);

    // R8
    pulse_upd();
    chk("R8 no set while disabled", {31'b0, flag}, 0);
    set_ctrl(1, 1);
    repeat (5) @(negedge clk);
    chk("R8 no set without strobe", {31'b0, flag}, 0);

    // R9
    pulse_upd();
    chk("R9 set", {31'b0, flag}, 1);
    sec = 7'h46;
    repeat (3) @(negedge clk);
    pulse_upd();
    chk("R9 sticky", {31'b0, flag}, 1);
    pulse_clr();
    chk("R9 cleared", {31'b0, flag}, 0);
    sec = 7'h45;
    upd = 1; flag_clr = 1;
    @(negedge clk); upd = 0; flag_clr = 0;
    chk("R9 set wins over clear", {31'b0, flag}, 1);

    // R10
    set_ctrl(1, 0);
    chk("R10 irq masked", {31'b0, irq}, 0);
    chk("R10 flag kept", {31'b0, flag}, 1);
    set_ctrl(1, 1);
    chk("R10 irq unmasked", {31'b0, irq}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule